// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides, frame by frame, whether a received frame is addressed to this station. The six bytes of the 48-bit destination address are shifted in as they arrive, and an evaluate strobe then starts a two-stage pipeline. The pipeline compares the address with one programmed station address. It recognises the all-ones broadcast address and looks the address up in a 64-bin hash table. The bin is chosen by folding the address onto six bits with XOR. An accept flag and a reason code come back a fixed number of cycles later.

Software programs the block through a narrow write-only port. That port holds a mode word, two station-address words and two hash words. Multicast and unicast hash hits are enabled separately, and the individual/group bit of the address picks which of the two enables applies. A copy-all mode accepts everything. A no-broadcast mode refuses the all-ones address.

Top module: `addr_accept_filter`

## Requirements
- R1: After reset, res_valid and accept are 0, reason is 0, and every configuration register is cleared.
- R2: Each byte presented with byte_valid shifts into the address, and the first byte received lands in address bits 7:0. A strobe evaluates the six most recently received bytes, so any bytes received before them are discarded.
- R3: res_valid is high for exactly one cycle, two clock edges after the edge that samples addr_strobe, and it is low one edge after the strobe. accept and reason are valid in that cycle and are 0 otherwise.
- R4: An address equal to the station address gets reason 1. The station address is formed with station-low bits 7:0 as the first address byte and station-high bits 15:0 as bytes 4 and 5.
- R5: Hash bin bit n is the XOR of address bits n+6k for k = 0..7. Bins 0–31 are bits 0–31 of the hash-low word, and bins 32–63 are bits 0–31 of the hash-high word.
- R6: With the multicast hash enable set, an address with bit 0 = 1 whose bin is set is accepted with reason 3.
- R7: With the unicast hash enable set, an address with bit 0 = 0 whose bin is set is accepted with reason 3. A set bin gives no hash hit when only the enable of the other address kind is set.
- R8: The all-ones address gets reason 2 when no-broadcast is clear. When no-broadcast is set it is rejected with reason 0 unless copy-all is set, even if its hash bin is enabled and set.
- R9: With copy-all set, every address is accepted with reason 4, whatever the other rules say.
- R10: A hash hit (reason 3) takes precedence over a broadcast (reason 2) and over a station match (reason 1).
- R11: Writes select a register by cfg_sel: 0 mode (bit0 copy-all, bit1 no-broadcast, bit2 multicast hash enable, bit3 unicast hash enable), 1 station low, 2 station high, 3 hash low, 4 hash high. Writes to selects 5–7 change nothing.
- R12: An address that meets no rule gets accept 0 and reason 0. The reason codes are 0 reject, 1 station, 2 broadcast, 3 hash, 4 copy-all, and accept is 1 exactly when reason is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| byte_valid | input | 1 | Address byte present on byte_data |
| byte_data | input | 8 | Destination address byte, reception order |
| addr_strobe | input | 1 | Evaluate the assembled address |
| res_valid | output | 1 | Result valid pulse |
| accept | output | 1 | Frame accepted |
| reason | output | 3 | Match reason code |

## Verification
A decision is due in the second cycle after the clock edge that samples the strobe. The bench drives inputs on falling edges and samples one nanosecond after each rising edge. After every strobe it confirms three things: no result one edge later, the expected accept and reason two edges later, and the valid pulse gone by the third edge. Configuration writes complete a full cycle before the first address byte of the next evaluation, so each verdict depends only on settled registers.

// File: rtl/af_pkg.sv
package af_pkg;

  typedef enum logic [2:0] {
    RSN_REJECT  = 3'd0,
    RSN_STATION = 3'd1,
    RSN_BCAST   = 3'd2,
    RSN_HASH    = 3'd3,
    RSN_COPYALL = 3'd4
  } reason_e;

  // bit3 unicast hash, bit2 multicast hash, bit1 no-broadcast, bit0 copy-all
  typedef struct packed {
    logic uc_hash_en;
    logic mc_hash_en;
    logic no_bcast;
    logic copy_all;
  } mode_t;

  localparam int MODE_W = 4;

  // evaluation flags carried from the match stage to the decision stage
  typedef struct packed {
    logic copy_all;
    logic bc_block;
    logic bcast;
    logic hash_hit;
    logic stn_hit;
  } hit_t;

  localparam int SEL_MODE      = 0;
  localparam int SEL_STN_LO    = 1;
  localparam int SEL_STN_HI    = 2;
  localparam int SEL_HASH_BASE = 3;

endpackage

// File: rtl/af_cfg_regs.sv
module af_cfg_regs
  import af_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 48,
  parameter int BINS   = 64,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output mode_t             mode,
  output logic [ADDR_W-1:0] station,
  output logic [BINS-1:0]   hash_tab
);
  localparam int HASH_WORDS = BINS / DATA_W;
  localparam int STN_HI_W   = ADDR_W - DATA_W;

  logic [MODE_W-1:0]   mode_q;
  logic [DATA_W-1:0]   stn_lo_q;
  logic [STN_HI_W-1:0] stn_hi_q;
  logic [BINS-1:0]     hash_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      stn_lo_q <= '0;
      stn_hi_q <= '0;
      hash_q   <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_W'(SEL_MODE))   mode_q   <= cfg_wdata[MODE_W-1:0];
      if (cfg_sel == SEL_W'(SEL_STN_LO)) stn_lo_q <= cfg_wdata;
      if (cfg_sel == SEL_W'(SEL_STN_HI)) stn_hi_q <= cfg_wdata[STN_HI_W-1:0];
      for (int w = 0; w < HASH_WORDS; w++) begin
        if (cfg_sel == SEL_W'(SEL_HASH_BASE + w))
          hash_q[w*DATA_W +: DATA_W] <= cfg_wdata;
      end
    end
  end

  assign mode     = mode_t'(mode_q);
  assign station  = {stn_hi_q, stn_lo_q};
  assign hash_tab = hash_q;

  // R11: a mode write is visible on the next cycle
  p_mode_write_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_W'(SEL_MODE)) |=> (mode_q == $past(cfg_wdata[MODE_W-1:0])));

endmodule

// File: rtl/af_addr_capture.sv
module af_addr_capture #(
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W    = ADDR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  output logic [ADDR_W-1:0] da
);
  // newest byte enters at the top, so after ADDR_BYTES bytes the first one sits in bits 7:0
  always_ff @(posedge clk) begin
    if (rst)             da <= '0;
    else if (byte_valid) da <= {byte_data, da[ADDR_W-1:8]};
  end

  // R2: the most recent byte always occupies the top byte lane
  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> (da[ADDR_W-1 -: 8] == $past(byte_data)));

endmodule

// File: rtl/af_hash_index.sv
module af_hash_index #(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 6
) (
  input  logic [ADDR_W-1:0]    da,
  output logic [HASH_BITS-1:0] idx
);
  for (genvar n = 0; n < HASH_BITS; n++) begin : g_fold
    logic [ADDR_W-1:0] tap;
    for (genvar b = 0; b < ADDR_W; b++) begin : g_tap
      assign tap[b] = ((b % HASH_BITS) == n);
    end
    assign idx[n] = ^(da & tap);
  end
endmodule

// File: rtl/af_match_stage.sv
module af_match_stage
  import af_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int HASH_BITS = 6,
  localparam int BINS     = 1 << HASH_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_strobe,
  input  logic [ADDR_W-1:0] da,
  input  mode_t             mode,
  input  logic [ADDR_W-1:0] station,
  input  logic [BINS-1:0]   hash_tab,
  output logic              s1_valid,
  output hit_t              s1
);
  logic [HASH_BITS-1:0] idx;
  logic group_addr, bin_set, is_bcast;
  hit_t hit_d;

  af_hash_index #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) u_hash (
    .da  (da),
    .idx (idx)
  );

  always_comb begin
    group_addr     = da[0];
    bin_set        = hash_tab[idx];
    is_bcast       = &da;
    hit_d.copy_all = mode.copy_all;
    hit_d.bcast    = is_bcast;
    hit_d.bc_block = is_bcast && mode.no_bcast;
    hit_d.hash_hit = bin_set && (group_addr ? mode.mc_hash_en : mode.uc_hash_en);
    hit_d.stn_hit  = (da == station);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1       <= '0;
    end else begin
      s1_valid <= addr_strobe;
      if (addr_strobe) s1 <= hit_d;
    end
  end

  // R7: an individual address never hashes in while unicast hashing is off
  p_uc_gate_r7: assert property (@(posedge clk) disable iff (rst)
    (addr_strobe && !da[0] && !mode.uc_hash_en) |=> !s1.hash_hit);

  // R6: a group address never hashes in while multicast hashing is off
  p_mc_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (addr_strobe && da[0] && !mode.mc_hash_en) |=> !s1.hash_hit);

endmodule

// File: rtl/af_decide.sv
module af_decide
  import af_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    s1_valid,
  input  hit_t    s1,
  output logic    res_valid,
  output logic    accept,
  output reason_e reason
);
  reason_e nxt;

  // priority from highest: copy-all, broadcast block, hash, broadcast, station
  always_comb begin
    nxt = RSN_REJECT;
    if (s1.copy_all)      nxt = RSN_COPYALL;
    else if (s1.bc_block) nxt = RSN_REJECT;
    else if (s1.hash_hit) nxt = RSN_HASH;
    else if (s1.bcast)    nxt = RSN_BCAST;
    else if (s1.stn_hit)  nxt = RSN_STATION;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      accept    <= 1'b0;
      reason    <= RSN_REJECT;
    end else begin
      res_valid <= s1_valid;
      accept    <= s1_valid && (nxt != RSN_REJECT);
      reason    <= s1_valid ? nxt : RSN_REJECT;
    end
  end

  p_copyall_r9: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1.copy_all) |=> (accept && reason == RSN_COPYALL));

  p_nobcast_r8: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1.bc_block && !s1.copy_all) |=> (!accept && reason == RSN_REJECT));

  p_hash_prio_r10: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1.hash_hit && !s1.copy_all && !s1.bc_block) |=> (reason == RSN_HASH));

endmodule

// File: rtl/addr_accept_filter.sv
module addr_accept_filter
  import af_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int DATA_W     = 32,
  parameter int SEL_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              addr_strobe,
  output logic              res_valid,
  output logic              accept,
  output logic [2:0]        reason
);
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int BINS   = 1 << HASH_BITS;

  mode_t             mode;
  logic [ADDR_W-1:0] station;
  logic [BINS-1:0]   hash_tab;
  logic [ADDR_W-1:0] da;
  logic              s1_valid;
  hit_t              s1;
  reason_e           reason_q;

  af_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BINS(BINS), .SEL_W(SEL_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .mode      (mode),
    .station   (station),
    .hash_tab  (hash_tab)
  );

  af_addr_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .da         (da)
  );

  af_match_stage #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) u_match (
    .clk         (clk),
    .rst         (rst),
    .addr_strobe (addr_strobe),
    .da          (da),
    .mode        (mode),
    .station     (station),
    .hash_tab    (hash_tab),
    .s1_valid    (s1_valid),
    .s1          (s1)
  );

  af_decide u_dec (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .s1        (s1),
    .res_valid (res_valid),
    .accept    (accept),
    .reason    (reason_q)
  );

  assign reason = reason_q;

  // R3: a strobe produces the result pulse on the second edge
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |=> s1_valid);
  p_result_r3: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> res_valid);
  // R12: accept and a non-zero reason go together
  p_accept_reason_r12: assert property (@(posedge clk) disable iff (rst)
    accept == (reason != 3'd0));

endmodule

// File: tb/addr_accept_filter_bench.sv
`timescale 1ns/1ps
module addr_accept_filter_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        addr_strobe = 1'b0;
  logic        res_valid, accept;
  logic [2:0]  reason;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_accept_filter u_addr_accept_filter (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .byte_valid(byte_valid), .byte_data(byte_data), .addr_strobe(addr_strobe),
    .res_valid(res_valid), .accept(accept), .reason(reason)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R5 bin function, written from the requirement
  function automatic logic [5:0] bin_of(input logic [47:0] a);
    logic [5:0] r = '0;
    for (int n = 0; n < 6; n++)
      for (int k = 0; k < 8; k++) r[n] = r[n] ^ a[n + 6*k];
    return r;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_cfg();
    for (int s = 0; s < 5; s++) wr(3'(s), 32'h0);
  endtask

  task automatic send(input logic [47:0] a, input int lead, input logic [2:0] exp, input string req);
    for (int i = 0; i < lead; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_data = 8'hC3 ^ 8'(i);
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); byte_valid = 1'b1; byte_data = a[8*i +: 8];
    end
    @(negedge clk); byte_valid = 1'b0; addr_strobe = 1'b1;
    @(posedge clk); #1;
    chk(res_valid == 1'b0, "R3", "early valid", 48'(res_valid), 48'h0);
    @(negedge clk); addr_strobe = 1'b0;
    @(posedge clk); #1;
    chk(res_valid == 1'b1, "R3", "valid due", 48'(res_valid), 48'h1);
    chk(reason == exp, req, "reason", 48'(reason), 48'(exp));
    chk(accept == (exp != 3'd0), req, "accept", 48'(accept), 48'(exp != 3'd0));
    @(posedge clk); #1;
    chk(res_valid == 1'b0 && accept == 1'b0, "R3", "pulse ended", 48'({res_valid, accept}), 48'h0);
  endtask

  localparam logic [47:0] STN = 48'h5544_3322_1102;

  task automatic t_reset();
    chk(res_valid == 1'b0 && accept == 1'b0 && reason == 3'd0, "R1", "reset outputs",
        48'({res_valid, accept, reason}), 48'h0);
    send(48'h1122_3344_5566, 0, 3'd0, "R1");   // cleared config: nothing accepts
  endtask

  task automatic t_station();
    clear_cfg();
    wr(3'd1, 32'h3322_1102);
    wr(3'd2, 32'h0000_5544);
    send(STN, 0, 3'd1, "R4");
    send(STN ^ 48'h0100_0000_0000, 0, 3'd0, "R12");
    send(STN, 2, 3'd1, "R2");                // leading bytes are pushed out
  endtask

  task automatic t_unicast();
    logic [47:0] a = 48'h0000_1234_5678;     // bit 0 = 0
    logic [5:0] b = bin_of(a);
    clear_cfg();
    if (b < 32) wr(3'd3, 32'h1 << b); else wr(3'd4, 32'h1 << (b - 32));
    wr(3'd0, 32'h8);
    send(a, 0, 3'd3, "R7");
    wr(3'd0, 32'h4);
    send(a, 0, 3'd0, "R7");
  endtask

  task automatic t_multicast();
    logic [47:0] a31 = 48'h0000_0004_101F;   // bin 31, group bit set
    logic [47:0] a32 = 48'h0000_0004_1061;   // bin 32, group bit set
    clear_cfg();
    chk(bin_of(a31) == 6'd31 && bin_of(a32) == 6'd32, "R5", "bench bins",
        48'({bin_of(a31), bin_of(a32)}), 48'({6'd31, 6'd32}));
    wr(3'd3, 32'h8000_0000);
    wr(3'd0, 32'h4);
    send(a31, 0, 3'd3, "R6");
    send(a32, 0, 3'd0, "R5");
    wr(3'd4, 32'h0000_0001);
    send(a32, 0, 3'd3, "R5");
    wr(3'd3, 32'h0);
    send(a31, 0, 3'd0, "R5");
    wr(3'd0, 32'h8);
    send(a32, 0, 3'd0, "R6");                // group address needs multicast enable
  endtask

  task automatic t_broadcast();
    clear_cfg();
    send(48'hFFFF_FFFF_FFFF, 0, 3'd2, "R8");
    wr(3'd0, 32'h2);
    send(48'hFFFF_FFFF_FFFF, 0, 3'd0, "R8");
    wr(3'd3, 32'h1);                         // all-ones address folds to bin 0
    wr(3'd0, 32'h6);
    send(48'hFFFF_FFFF_FFFF, 0, 3'd0, "R8");
    wr(3'd0, 32'h4);
    send(48'hFFFF_FFFF_FFFF, 0, 3'd3, "R10");
  endtask

  task automatic t_priority();
    logic [5:0] b = bin_of(STN);
    clear_cfg();
    wr(3'd1, 32'h3322_1102);
    wr(3'd2, 32'h0000_5544);
    if (b < 32) wr(3'd3, 32'h1 << b); else wr(3'd4, 32'h1 << (b - 32));
    wr(3'd0, 32'h8);
    send(STN, 0, 3'd3, "R10");
  endtask

  task automatic t_copyall();
    clear_cfg();
    wr(3'd0, 32'h1);
    send(48'h0A0B_0C0D_0E10, 0, 3'd4, "R9");
    wr(3'd0, 32'h3);
    send(48'hFFFF_FFFF_FFFF, 0, 3'd4, "R9");
  endtask

  task automatic t_unmapped();
    clear_cfg();
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    send(48'h0000_0000_0100, 0, 3'd0, "R11");
    send(48'h0000_0000_0001, 0, 3'd0, "R11");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    t_reset();
    t_station();
    t_unicast();
    t_multicast();
    t_broadcast();
    t_priority();
    t_copyall();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog expired: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule